// File: doc/BRIEF.md
# Pixel FIFO with Line Fill Monitor

This block holds incoming parallel pixels in a small FIFO that sits between the pixel side and a byte-rate packet engine. The engine signals the horizontal phase it is currently generating (sync, back porch, payload, front porch) and pulls pixels through the read port. The fill level follows a fixed pattern within a line. It climbs while sync and back porch packets are produced and nothing is read. It holds steady during payload, because pixels leave as fast as they arrive. It empties during the front porch.

To check whether the horizontal timing values suit the two clock rates, the block samples the level half way through each payload. It then reports the signed change against the previous line's sample. A steady non-zero change means the pixel rate and the byte rate are mismatched, and the front porch length needs trimming. A pulse also marks a front porch that ended with pixels still held. Overflow and underflow raise sticky flags, each cleared by writing a one. The two clock domains are modelled as one clock with per-cycle enables.

Top module: `pixfifo_mon`

## Requirements
- R1: While reset is asserted and on the first cycle after it, fillLevel is 0 and rdValid, snapValid, deltaValid, ovfErr, udfErr and drainMiss are all 0.
- R2: Pixels leave the read port in the order they were accepted. An accepted read in one cycle gives rdValid=1 with that pixel on rdData in the next cycle, and rdValid=0 otherwise.
- R3: fillLevel rises by one on an accepted write and falls by one on an accepted read. It is unchanged when both or neither occur, and never exceeds DEPTH.
- R4: A write while the FIFO is full and no read is accepted is dropped and sets ovfErr, which stays set. A write while full together with an accepted read is taken.
- R5: A read request while the FIFO is empty is ignored: fillLevel stays 0, rdValid stays 0, and udfErr is set and stays set.
- R6: errClr[0]=1 clears ovfErr and errClr[1]=1 clears udfErr. A new error in the same cycle wins over the clear.
- R7: The phase input is encoded as 0 sync, 1 back porch, 2 payload, 3 front porch. Accepted reads in phase 2 are counted, and the count restarts whenever the phase is not 2. The read that brings the count to floor(activeCount/2) loads snapLevel with the level after that cycle, and snapValid pulses for one cycle. If floor(activeCount/2) is 0, no snapshot is taken.
- R8: Each snapshot after the first since reset pulses deltaValid together with snapValid. At the same time, lineDelta carries the new snapshot minus the previous one as a two's-complement value.
- R9: When the phase changes from 3 to any other value while fillLevel is non-zero, drainMiss pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel write enable |
| pixData | input | PIX_W | Pixel to write |
| phase | input | 2 | Horizontal phase from the packet engine |
| rdReq | input | 1 | Read request from the packet engine |
| activeCount | input | CNT_W | Programmed active pixels per line |
| errClr | input | 2 | Write-one clear: bit 0 overflow, bit 1 underflow |
| rdData | output | PIX_W | Pixel read out |
| rdValid | output | 1 | rdData holds a pixel from the previous cycle's read |
| fillLevel | output | LVL_W | Pixels currently held |
| snapLevel | output | LVL_W | Level sampled at mid-payload |
| snapValid | output | 1 | One-cycle pulse on a new snapshot |
| lineDelta | output | LVL_W+1 | Signed change between the last two snapshots |
| deltaValid | output | 1 | One-cycle pulse when lineDelta is new |
| ovfErr | output | 1 | Sticky overflow flag |
| udfErr | output | 1 | Sticky underflow flag |
| drainMiss | output | 1 | Front porch ended with data left |

## Verification
The bench builds the block with DEPTH=8, PIX_W=16 and CNT_W=8. The shallow FIFO lets a short burst reach the full state, so the cases of a dropped write, a write taken while full together with a read, and a clear that loses to a new error all fall within a few cycles. An active count of 8 puts the snapshot four reads into payload. The bench runs balanced lines, which give zero drift, and lines with one surplus pixel each, which give a drift of +1 and leftover front porch data. It also uses an active count of 1 to show that no snapshot is taken.

// File: rtl/pixfifo_pkg.sv
package pixfifo_pkg;
  typedef enum logic [1:0] {
    PH_SYNC    = 2'd0,
    PH_BPORCH  = 2'd1,
    PH_PAYLOAD = 2'd2,
    PH_FPORCH  = 2'd3
  } linePhase_t;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic snapEn;
  } fifoStrobe_t;
endpackage

// File: rtl/pixfifo_ctrl.sv
module pixfifo_ctrl
  import pixfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 12,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             rdReq,
  input  logic [1:0]       phase,
  input  logic [CNT_W-1:0] activeCount,
  input  logic [1:0]       errClr,
  input  logic [LVL_W-1:0] fillLevel,
  output fifoStrobe_t      strobes,
  output logic             ovfErr,
  output logic             udfErr,
  output logic             drainMiss
);
  linePhase_t       curPhase;
  linePhase_t       prevPhase;
  logic             isFull;
  logic             isEmpty;
  logic [CNT_W-1:0] midPoint;
  logic [CNT_W-1:0] payCnt;
  logic             dropWr;
  logic             missRd;

  assign curPhase = linePhase_t'(phase);
  assign isFull   = (fillLevel == LVL_W'(DEPTH));
  assign isEmpty  = (fillLevel == '0);
  assign midPoint = activeCount >> 1;

  always_comb begin
    strobes.rdEn   = rdReq && !isEmpty;
    strobes.wrEn   = pixValid && (!isFull || strobes.rdEn);
    strobes.snapEn = strobes.rdEn && (curPhase == PH_PAYLOAD) &&
                     (midPoint != '0) && ((payCnt + CNT_W'(1)) == midPoint);
    dropWr         = pixValid && !strobes.wrEn;
    missRd         = rdReq && !strobes.rdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payCnt    <= '0;
      prevPhase <= PH_SYNC;
      drainMiss <= 1'b0;
      ovfErr    <= 1'b0;
      udfErr    <= 1'b0;
    end else begin
      if (curPhase != PH_PAYLOAD) payCnt <= '0;
      else if (strobes.rdEn)      payCnt <= payCnt + CNT_W'(1);
      prevPhase <= curPhase;
      drainMiss <= (prevPhase == PH_FPORCH) && (curPhase != PH_FPORCH) && !isEmpty;
      if (dropWr)         ovfErr <= 1'b1;
      else if (errClr[0]) ovfErr <= 1'b0;
      if (missRd)         udfErr <= 1'b1;
      else if (errClr[1]) udfErr <= 1'b0;
    end
  end
endmodule

// File: rtl/pixfifo_dp.sv
module pixfifo_dp
  import pixfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PIX_W = 24,
  parameter int LVL_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fifoStrobe_t             strobes,
  input  logic [PIX_W-1:0]        pixData,
  output logic [PIX_W-1:0]        rdData,
  output logic                    rdValid,
  output logic [LVL_W-1:0]        fillLevel,
  output logic [LVL_W-1:0]        snapLevel,
  output logic                    snapValid,
  output logic signed [LVL_W:0]   lineDelta,
  output logic                    deltaValid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [LVL_W-1:0] fillNext;
  logic             havePrev;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    case ({strobes.wrEn, strobes.rdEn})
      2'b10:   fillNext = fillLevel + LVL_W'(1);
      2'b01:   fillNext = fillLevel - LVL_W'(1);
      default: fillNext = fillLevel;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrPtr] <= pixData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      fillLevel  <= '0;
      rdData     <= '0;
      rdValid    <= 1'b0;
      snapLevel  <= '0;
      snapValid  <= 1'b0;
      lineDelta  <= '0;
      deltaValid <= 1'b0;
      havePrev   <= 1'b0;
    end else begin
      fillLevel <= fillNext;
      rdValid   <= strobes.rdEn;
      if (strobes.wrEn) wrPtr <= bump(wrPtr);
      if (strobes.rdEn) begin
        rdPtr  <= bump(rdPtr);
        rdData <= mem[rdPtr];
      end
      snapValid  <= strobes.snapEn;
      deltaValid <= strobes.snapEn && havePrev;
      if (strobes.snapEn) begin
        snapLevel <= fillNext;
        lineDelta <= $signed({1'b0, fillNext}) - $signed({1'b0, snapLevel});
        havePrev  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixfifo_mon.sv
module pixfifo_mon
  import pixfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PIX_W = 24,
  parameter int CNT_W = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pixValid,
  input  logic [PIX_W-1:0]      pixData,
  input  logic [1:0]            phase,
  input  logic                  rdReq,
  input  logic [CNT_W-1:0]      activeCount,
  input  logic [1:0]            errClr,
  output logic [PIX_W-1:0]      rdData,
  output logic                  rdValid,
  output logic [LVL_W-1:0]      fillLevel,
  output logic [LVL_W-1:0]      snapLevel,
  output logic                  snapValid,
  output logic signed [LVL_W:0] lineDelta,
  output logic                  deltaValid,
  output logic                  ovfErr,
  output logic                  udfErr,
  output logic                  drainMiss
);
  fifoStrobe_t strobes;

  pixfifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .rdReq(rdReq), .phase(phase),
    .activeCount(activeCount), .errClr(errClr), .fillLevel(fillLevel),
    .strobes(strobes), .ovfErr(ovfErr), .udfErr(udfErr), .drainMiss(drainMiss)
  );

  pixfifo_dp #(.DEPTH(DEPTH), .PIX_W(PIX_W), .LVL_W(LVL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixData(pixData),
    .rdData(rdData), .rdValid(rdValid), .fillLevel(fillLevel),
    .snapLevel(snapLevel), .snapValid(snapValid), .lineDelta(lineDelta),
    .deltaValid(deltaValid)
  );
endmodule

// File: rtl/pixfifo_chk.sv
module pixfifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       phase,
  input logic [1:0]       errClr,
  input logic [LVL_W-1:0] fillLevel,
  input logic             rdValid,
  input logic             snapValid,
  input logic             deltaValid,
  input logic             ovfErr,
  input logic             udfErr,
  input logic             drainMiss
);
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(DEPTH));

  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fillLevel == $past(fillLevel)) ||
             (fillLevel == $past(fillLevel) + LVL_W'(1)) ||
             (fillLevel == $past(fillLevel) - LVL_W'(1)));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr && !errClr[0] |=> ovfErr);

  assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    udfErr && !errClr[1] |=> udfErr);

  assert_read_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(fillLevel) != '0);

  assert_snap_in_payload_R7: assert property (@(posedge clk) disable iff (!rstN)
    snapValid |-> $past(phase) == 2'd2);

  assert_delta_with_snap_R8: assert property (@(posedge clk) disable iff (!rstN)
    deltaValid |-> snapValid);

  assert_drain_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    drainMiss |-> ($past(fillLevel) != '0) && ($past(phase) != 2'd3));
endmodule

bind pixfifo_mon pixfifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .phase(phase), .errClr(errClr), .fillLevel(fillLevel),
  .rdValid(rdValid), .snapValid(snapValid), .deltaValid(deltaValid),
  .ovfErr(ovfErr), .udfErr(udfErr), .drainMiss(drainMiss)
);

// File: tb/pixfifo_mon_tb_top.sv
module pixfifo_mon_tb_top;
  localparam int DEPTH = 8;
  localparam int PIX_W = 16;
  localparam int CNT_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0;
  logic [PIX_W-1:0] pixData = '0;
  logic [1:0] phase = 2'd0;
  logic rdReq = 1'b0;
  logic [CNT_W-1:0] activeCount = CNT_W'(8);
  logic [1:0] errClr = 2'b00;
  logic [PIX_W-1:0] rdData;
  logic rdValid, snapValid, deltaValid, ovfErr, udfErr, drainMiss;
  logic [LVL_W-1:0] fillLevel, snapLevel;
  logic signed [LVL_W:0] lineDelta;

  pixfifo_mon #(.DEPTH(DEPTH), .PIX_W(PIX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData), .phase(phase),
    .rdReq(rdReq), .activeCount(activeCount), .errClr(errClr), .rdData(rdData),
    .rdValid(rdValid), .fillLevel(fillLevel), .snapLevel(snapLevel),
    .snapValid(snapValid), .lineDelta(lineDelta), .deltaValid(deltaValid),
    .ovfErr(ovfErr), .udfErr(udfErr), .drainMiss(drainMiss)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  logic [PIX_W-1:0] q[$];
  logic [PIX_W-1:0] mRdData = '0;
  bit mRdValid, mSnapValid, mDeltaValid, mOvf, mUdf, mDrain, mHave;
  int mSnap, mDelta, mPay, mPrevPh;
  logic [PIX_W-1:0] dataCtr = 16'h0100;

  // observations for directed checks
  int snapSeen, deltaSeen, drainSeen, lastDelta;

  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic modelReset();
    q.delete();
    mRdValid = 0; mSnapValid = 0; mDeltaValid = 0; mOvf = 0; mUdf = 0;
    mDrain = 0; mHave = 0; mSnap = 0; mDelta = 0; mPay = 0; mPrevPh = 0;
  endtask

  task automatic compareAll();
    check(fillLevel == LVL_W'(q.size()), "R3 fillLevel", int'(fillLevel), q.size());
    check(rdValid == mRdValid, "R2 rdValid", int'(rdValid), int'(mRdValid));
    if (mRdValid) check(rdData == mRdData, "R2 rdData", int'(rdData), int'(mRdData));
    check(snapValid == mSnapValid, "R7 snapValid", int'(snapValid), int'(mSnapValid));
    check(int'(snapLevel) == mSnap, "R7 snapLevel", int'(snapLevel), mSnap);
    check(deltaValid == mDeltaValid, "R8 deltaValid", int'(deltaValid), int'(mDeltaValid));
    if (mDeltaValid) check(int'(lineDelta) == mDelta, "R8 lineDelta", int'(lineDelta), mDelta);
    check(ovfErr == mOvf, "R4 ovfErr", int'(ovfErr), int'(mOvf));
    check(udfErr == mUdf, "R5 udfErr", int'(udfErr), int'(mUdf));
    check(drainMiss == mDrain, "R9 drainMiss", int'(drainMiss), int'(mDrain));
    if (snapValid) snapSeen++;
    if (deltaValid) begin deltaSeen++; lastDelta = int'(lineDelta); end
    if (drainMiss) drainSeen++;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input bit r, input logic [1:0] ph, input logic [1:0] clr);
    int sizeB, mid;
    bit rdAcc, wrAcc;
    pixValid = v; rdReq = r; phase = ph; errClr = clr; pixData = dataCtr;
    @(posedge clk);
    if (!rstN) modelReset();
    else begin
      sizeB = q.size();
      rdAcc = r && (sizeB > 0);
      wrAcc = v && ((sizeB < DEPTH) || rdAcc);
      mRdValid = rdAcc;
      if (rdAcc) mRdData = q.pop_front();
      if (wrAcc) q.push_back(dataCtr);
      mid = int'(activeCount) / 2;
      mSnapValid = 0; mDeltaValid = 0;
      if (ph == 2'd2 && rdAcc && mid != 0 && mPay + 1 == mid) begin
        if (mHave) begin mDeltaValid = 1; mDelta = q.size() - mSnap; end
        mSnap = q.size(); mHave = 1; mSnapValid = 1;
      end
      if (ph != 2'd2) mPay = 0; else if (rdAcc) mPay++;
      mDrain = (mPrevPh == 3) && (ph != 2'd3) && (sizeB != 0);
      mPrevPh = int'(ph);
      if (v && !wrAcc) mOvf = 1; else if (clr[0]) mOvf = 0;
      if (r && !rdAcc) mUdf = 1; else if (clr[1]) mUdf = 0;
    end
    if (v) dataCtr++;
    @(negedge clk);
    compareAll();
  endtask

  task automatic runLine(input int s, input int b, input int p, input int f);
    for (int i = 0; i < s; i++) step(1, 0, 2'd0, 2'b00);
    for (int i = 0; i < b; i++) step(1, 0, 2'd1, 2'b00);
    for (int i = 0; i < p; i++) step(1, 1, 2'd2, 2'b00);
    for (int i = 0; i < f; i++) step(0, 1, 2'd3, 2'b00);
  endtask

  initial begin
    modelReset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(0, 0, 2'd0, 2'b00);
    // R1: reset state, during reset
    check(fillLevel == '0 && !rdValid && !snapValid && !deltaValid && !ovfErr && !udfErr && !drainMiss,
          "R1 reset state", int'(fillLevel), 0);
    rstN = 1'b1;
    step(0, 0, 2'd0, 2'b00);
    check(fillLevel == '0 && !ovfErr && !udfErr && !snapValid, "R1 after release", int'(fillLevel), 0);

    // balanced lines: level 4 at mid-payload, zero drift
    activeCount = CNT_W'(8);
    runLine(2, 2, 8, 4);
    check(snapSeen == 1, "R7 one snapshot per line", snapSeen, 1);
    check(int'(snapLevel) == 4, "R7 mid-payload level", int'(snapLevel), 4);
    check(deltaSeen == 0, "R8 no delta on first snapshot", deltaSeen, 0);
    runLine(2, 2, 8, 4);
    runLine(2, 2, 8, 4);
    check(deltaSeen == 2 && lastDelta == 0, "R8 balanced drift", lastDelta, 0);
    check(drainSeen == 0, "R9 drained lines", drainSeen, 0);
    check(fillLevel == '0, "R3 empty after front porch", int'(fillLevel), 0);

    // one surplus pixel per line: drift of +1 and leftover data
    runLine(2, 3, 8, 4);
    runLine(2, 3, 8, 4);
    check(lastDelta == 1, "R8 positive drift", lastDelta, 1);
    runLine(2, 3, 8, 4);
    check(drainSeen >= 2, "R9 leftover after front porch", drainSeen, 2);
    check(int'(snapLevel) == 7, "R7 growing snapshot", int'(snapLevel), 7);

    // drain, then read when empty
    while (q.size() > 0) step(0, 1, 2'd0, 2'b00);
    step(0, 1, 2'd0, 2'b00);
    check(udfErr && fillLevel == '0 && !rdValid, "R5 read when empty ignored", int'(fillLevel), 0);
    step(0, 0, 2'd0, 2'b10);
    check(!udfErr, "R6 clear underflow", int'(udfErr), 0);

    // overflow with DEPTH=8
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 2'd0, 2'b00);
    check(ovfErr && fillLevel == LVL_W'(DEPTH), "R4 overflow drops", int'(fillLevel), DEPTH);
    step(1, 1, 2'd0, 2'b00);
    check(fillLevel == LVL_W'(DEPTH), "R4 write with read while full", int'(fillLevel), DEPTH);
    step(1, 0, 2'd0, 2'b01);
    check(ovfErr, "R6 new error wins over clear", int'(ovfErr), 1);
    step(0, 0, 2'd0, 2'b01);
    check(!ovfErr, "R6 clear overflow", int'(ovfErr), 0);
    while (q.size() > 0) step(0, 1, 2'd0, 2'b00);

    // midpoint of zero: no snapshot
    activeCount = CNT_W'(1);
    snapSeen = 0;
    runLine(1, 1, 1, 2);
    check(snapSeen == 0, "R7 no snapshot for zero midpoint", snapSeen, 0);

    // odd active count: midpoint floor(5/2)=2
    activeCount = CNT_W'(5);
    runLine(1, 1, 5, 2);
    check(snapSeen == 1 && int'(snapLevel) == 2, "R7 odd active count", int'(snapLevel), 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule